// File: doc/BRIEF.md
# Acquisition Interrupt Status Register

This block collects event pulses from a data-acquisition sequencer and turns them into latched interrupt flags, a running count of unread conversion results, and one level-sensitive interrupt output. The events come from elsewhere in the system: a limit crossing in watchdog mode, an instruction load with its 3-bit number, a result written to the result FIFO, a FIFO read, auto-zero done, full calibration done, a pause, and a return from standby. The ADC core, the sequencer and the FIFO storage are not part of this block.

Two of the flags are not simple event latches. The first is set when the sequencer loads the instruction number held in the enable register. The second is set when the unread-result count moves onto a programmed threshold. The status word is always visible on a read port. It holds the eight flags and the live unread count. A read strobe clears all the flags, and so does a soft device reset. A synchronous write port with byte lanes loads the enable register, which holds the per-flag enable mask, the instruction number to match and the FIFO threshold.

Top module: `acq_irq_status`

## Requirements
- R1: After rst_n is held low for a clock edge, the status word is 0x0000, irq is 0 and the enable register is all zeros.
- R2: The status word carries the flags in bits 7..0 and the unread count in bits 15..11. Bits 10..8 read as 0, and flag bit 6 is unused and always reads 0.
- R3: Each event sets its flag at the next clock edge whether or not that flag is enabled. The mapping is: limit crossing to bit 0, auto-zero done to bit 3, calibration done to bit 4, pause to bit 5, standby-ready to bit 7.
- R4: Flag bit 1 sets when ld_valid is high and ld_num equals enable bits 10..8. A load with any other number leaves it unchanged.
- R5: The unread count rises by one on a FIFO write and falls by one on a FIFO read. It holds when both happen in the same cycle, and it saturates at 31 and at 0.
- R6: Flag bit 2 sets only in a cycle where the count changes and its new value equals enable bits 15..11. A steady count equal to the threshold does not set the flag again after a clear.
- R7: A high rd_stb clears all flags at the next edge. A high soft_clr does the same.
- R8: A flag event in the same cycle as a clearing strobe leaves that flag set after the edge.
- R9: irq is 1 exactly while some flag bit and the matching enable bit (7..0) are both 1.
- R10: A write with wr_be[0] loads enable bits 7..0, and a write with wr_be[1] loads enable bits 15..8. A lane whose byte enable is low keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Device reset request from configuration; clears flags |
| ev_limit | input | 1 | Watchdog limit crossing pulse |
| ld_valid | input | 1 | Sequencer instruction-load pulse |
| ld_num | input | 3 | Number of the instruction being loaded |
| fifo_wr | input | 1 | A result was written into the FIFO |
| fifo_rd | input | 1 | A result was read from the FIFO |
| ev_autozero | input | 1 | Auto-zero cycle finished |
| ev_calib | input | 1 | Full calibration finished |
| ev_pause | input | 1 | Pause reached |
| ev_ready | input | 1 | Back from standby and ready |
| wr_en | input | 1 | Enable-register write strobe |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Enable-register write data |
| rd_stb | input | 1 | Status read strobe; clears flags |
| rd_data | output | 16 | Live status word |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle. A clearing read can coincide with a new flag event, and a FIFO write can coincide with a FIFO read. The bench drives a read strobe together with a pause pulse and expects only the pause flag to remain after the edge. It drives a write and a read of the FIFO together and expects the count to stay where it was. The threshold flag is also checked across a clear while the count sits on the threshold, to show that it is not set again.

// File: rtl/acq_irq_pkg.sv
// Package: shared sizes and flag bit positions for the acquisition
// interrupt status logic. Assumes a 16-bit status/enable word.
package acq_irq_pkg;
    localparam int STATUS_W = 16;
    localparam int NFLAG    = 8;
    localparam int CNT_W    = 5;
    localparam int NUM_W    = 3;
    localparam int NUM_LSB  = 8;
    localparam int THR_LSB  = STATUS_W - CNT_W;
    localparam int PAD_W    = THR_LSB - NFLAG;

    localparam int FB_LIMIT = 0;
    localparam int FB_MATCH = 1;
    localparam int FB_THR   = 2;
    localparam int FB_AZ    = 3;
    localparam int FB_CAL   = 4;
    localparam int FB_PAUSE = 5;
    localparam int FB_SPARE = 6;
    localparam int FB_READY = 7;

    typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/acq_unread_cnt.sv
// Module: saturating up/down count of unread FIFO results, with a
// pulse when the count steps onto a programmed threshold.
// Assumes push/pop are single-cycle qualified strobes.
module acq_unread_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             thr_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    logic             do_inc;
    logic             do_dec;
    logic [CNT_W-1:0] cnt_nxt;

    // Decide the step: push and pop together cancel, and the ends saturate.
    always_comb begin
        do_inc  = push && !pop && (cnt != CNT_MAX);
        do_dec  = pop && !push && (cnt != CNT_MIN);
        cnt_nxt = cnt;
        if (do_inc) begin
            cnt_nxt = cnt + 1'b1;
        end else if (do_dec) begin
            cnt_nxt = cnt - 1'b1;
        end
    end

    // The threshold compare counts only when the value moves.
    assign thr_hit = (do_inc || do_dec) && (cnt_nxt == thr);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/acq_ien_reg.sv
// Module: byte-lane writable enable register, reset to zero.
// Assumes DW is a whole number of bytes.
module acq_ien_reg #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW/8-1:0] wr_be,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   q
);
    localparam int NBYTE = DW / 8;

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        // One byte lane: loads only when its byte enable is high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b*8 +: 8] <= '0;
            end else if (wr_en && wr_be[b]) begin
                q[b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/acq_flag_reg.sv
// Module: sticky flag bank. Clearing happens first, then new events
// are ORed in, so an event that meets a clear is kept. Bits outside
// USED are held at zero.
module acq_flag_reg #(
    parameter int              NF   = 8,
    parameter logic [NF-1:0]   USED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NF-1:0] set,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] flags_nxt;

    // Clear first, then set, then mask off the unused positions.
    always_comb begin
        flags_nxt = clr ? '0 : flags;
        flags_nxt = (flags_nxt | set) & USED;
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/acq_irq_status.sv
// Top: interrupt flags, unread count and enable register for the
// acquisition sequencer. The status word is combinational from
// registers. A read strobe or a soft clear empties the flags at the next edge.
module acq_irq_status
    import acq_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_clr,
    input  logic                ev_limit,
    input  logic                ld_valid,
    input  logic [NUM_W-1:0]    ld_num,
    input  logic                fifo_wr,
    input  logic                fifo_rd,
    input  logic                ev_autozero,
    input  logic                ev_calib,
    input  logic                ev_pause,
    input  logic                ev_ready,
    input  logic                wr_en,
    input  logic [1:0]          wr_be,
    input  logic [STATUS_W-1:0] wr_data,
    input  logic                rd_stb,
    output logic [STATUS_W-1:0] rd_data,
    output logic                irq
);
    localparam flag_vec_t USED_MASK = ~(flag_vec_t'(1) << FB_SPARE);

    logic [STATUS_W-1:0] ien_q;
    logic [CNT_W-1:0]    cnt;
    logic                thr_hit;
    logic                num_hit;
    flag_vec_t           set_vec;
    flag_vec_t           flags;

    acq_ien_reg #(.DW(STATUS_W)) u_ien (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .q       (ien_q)
    );

    acq_unread_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (fifo_wr),
        .pop     (fifo_rd),
        .thr     (ien_q[THR_LSB +: CNT_W]),
        .cnt     (cnt),
        .thr_hit (thr_hit)
    );

    // Instruction-number match for the load flag.
    assign num_hit = ld_valid && (ld_num == ien_q[NUM_LSB +: NUM_W]);

    // Gather the per-bit set requests.
    always_comb begin
        set_vec           = '0;
        set_vec[FB_LIMIT] = ev_limit;
        set_vec[FB_MATCH] = num_hit;
        set_vec[FB_THR]   = thr_hit;
        set_vec[FB_AZ]    = ev_autozero;
        set_vec[FB_CAL]   = ev_calib;
        set_vec[FB_PAUSE] = ev_pause;
        set_vec[FB_READY] = ev_ready;
    end

    acq_flag_reg #(.NF(NFLAG), .USED(USED_MASK)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rd_stb || soft_clr),
        .set   (set_vec),
        .flags (flags)
    );

    // Status word and interrupt output.
    assign rd_data = {cnt, {PAD_W{1'b0}}, flags};
    assign irq     = |(flags & ien_q[NFLAG-1:0]);
endmodule

// File: rtl/acq_irq_status_chk.sv
// Checker: temporal properties of the status block, bound to the top.
module acq_irq_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_clr,
    input logic        ev_pause,
    input logic        ev_autozero,
    input logic        ld_valid,
    input logic [2:0]  ld_num,
    input logic        fifo_wr,
    input logic        fifo_rd,
    input logic        rd_stb,
    input logic [15:0] rd_data,
    input logic [15:0] ien_q,
    input logic        irq
);
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[6] == 1'b0 && rd_data[10:8] == 3'b0); // R2
    AST_AZ_SETS: assert property (@(posedge clk) disable iff (!rst_n) ev_autozero |=> rd_data[3]); // R3
    AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (ld_valid && ld_num == ien_q[10:8]) |=> rd_data[1]); // R4
    AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n) (fifo_wr && !fifo_rd && rd_data[15:11] != 5'd31) |=> rd_data[15:11] == $past(rd_data[15:11]) + 5'd1); // R5
    AST_CNT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) (fifo_wr && fifo_rd) |=> $stable(rd_data[15:11])); // R5
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ((rd_stb || soft_clr) && !ev_pause) |=> !rd_data[5]); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (rd_stb && ev_pause) |=> rd_data[5]); // R8
    AST_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[7:0] == 8'h00) |-> !irq); // R9
endmodule

bind acq_irq_status acq_irq_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_clr    (soft_clr),
    .ev_pause    (ev_pause),
    .ev_autozero (ev_autozero),
    .ld_valid    (ld_valid),
    .ld_num      (ld_num),
    .fifo_wr     (fifo_wr),
    .fifo_rd     (fifo_rd),
    .rd_stb      (rd_stb),
    .rd_data     (rd_data),
    .ien_q       (ien_q),
    .irq         (irq)
);

// File: tb/acq_irq_status_test.sv
// Directed bench: one task per scenario, each checking its own results.
module acq_irq_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0, ev_limit = 1'b0, ld_valid = 1'b0;
    logic [2:0]  ld_num = '0;
    logic        fifo_wr = 1'b0, fifo_rd = 1'b0;
    logic        ev_autozero = 1'b0, ev_calib = 1'b0, ev_pause = 1'b0, ev_ready = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    acq_irq_status uut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .ev_limit(ev_limit),
        .ld_valid(ld_valid), .ld_num(ld_num), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
        .ev_autozero(ev_autozero), .ev_calib(ev_calib), .ev_pause(ev_pause),
        .ev_ready(ev_ready), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: inputs already driven, wait past the edge, drop all strobes.
    task automatic step();
        @(negedge clk);
        soft_clr = 0; ev_limit = 0; ld_valid = 0; fifo_wr = 0; fifo_rd = 0;
        ev_autozero = 0; ev_calib = 0; ev_pause = 0; ev_ready = 0;
        wr_en = 0; rd_stb = 0;
    endtask

    task automatic clear_flags();
        rd_stb = 1; step();
    endtask

    task automatic write_ien(input logic [1:0] be, input logic [15:0] d);
        wr_en = 1; wr_be = be; wr_data = d; step();
    endtask

    task automatic t_reset();
        check(rd_data == 16'h0000, "R1", rd_data, 16'h0000);
        check(irq == 1'b0, "R1", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_events();
        ev_limit = 1; step();
        check(rd_data == 16'h0001, "R3 limit", rd_data, 16'h0001);
        clear_flags();
        ev_autozero = 1; ev_calib = 1; ev_pause = 1; ev_ready = 1; step();
        check(rd_data == 16'h00B8, "R3 events", rd_data, 16'h00B8);
        check(irq == 1'b0, "R3 disabled irq", {15'b0, irq}, 16'h0000);
        clear_flags();
        check(rd_data == 16'h0000, "R7 read clear", rd_data, 16'h0000);
    endtask

    task automatic t_load_match();
        write_ien(2'b10, 16'h0500);
        ld_valid = 1; ld_num = 3'd4; step();
        check(rd_data[1] == 1'b0, "R4 mismatch", rd_data, 16'h0000);
        ld_valid = 1; ld_num = 3'd5; step();
        check(rd_data == 16'h0002, "R4 match", rd_data, 16'h0002);
        clear_flags();
    endtask

    task automatic t_count();
        write_ien(2'b10, 16'hF800);
        for (int i = 0; i < 3; i++) begin fifo_wr = 1; step(); end
        check(rd_data[15:11] == 5'd3, "R5 inc", {11'b0, rd_data[15:11]}, 16'd3);
        check(rd_data[10:8] == 3'd0, "R2 pad", rd_data, 16'h0000);
        fifo_wr = 1; fifo_rd = 1; step();
        check(rd_data[15:11] == 5'd3, "R5 both", {11'b0, rd_data[15:11]}, 16'd3);
        for (int i = 0; i < 4; i++) begin fifo_rd = 1; step(); end
        check(rd_data[15:11] == 5'd0, "R5 floor", {11'b0, rd_data[15:11]}, 16'd0);
        for (int i = 0; i < 33; i++) begin fifo_wr = 1; step(); end
        check(rd_data[15:11] == 5'd31, "R5 ceiling", {11'b0, rd_data[15:11]}, 16'd31);
        for (int i = 0; i < 31; i++) begin fifo_rd = 1; step(); end
        check(rd_data[15:11] == 5'd0, "R5 drain", {11'b0, rd_data[15:11]}, 16'd0);
        clear_flags();
    endtask

    task automatic t_threshold();
        write_ien(2'b10, 16'h1000);
        clear_flags();
        fifo_wr = 1; step();
        check(rd_data[2] == 1'b0, "R6 below", rd_data, 16'h0800);
        fifo_wr = 1; step();
        check(rd_data == 16'h1004, "R6 hit", rd_data, 16'h1004);
        clear_flags();
        step(); step();
        check(rd_data == 16'h1000, "R6 steady", rd_data, 16'h1000);
        fifo_wr = 1; step();
        fifo_rd = 1; step();
        check(rd_data == 16'h1004, "R6 return", rd_data, 16'h1004);
        fifo_rd = 1; step();
        fifo_rd = 1; step();
        clear_flags();
    endtask

    task automatic t_collide();
        rd_stb = 1; ev_pause = 1; step();
        check(rd_data == 16'h0020, "R8 event wins", rd_data, 16'h0020);
        ev_calib = 1; step();
        soft_clr = 1; step();
        check(rd_data == 16'h0000, "R7 soft clear", rd_data, 16'h0000);
    endtask

    task automatic t_irq_lanes();
        write_ien(2'b01, 16'h0008);
        ev_calib = 1; step();
        check(irq == 1'b0, "R9 masked", {15'b0, irq}, 16'h0000);
        ev_autozero = 1; step();
        check(irq == 1'b1, "R9 enabled", {15'b0, irq}, 16'h0001);
        clear_flags();
        check(irq == 1'b0, "R9 cleared", {15'b0, irq}, 16'h0000);
        write_ien(2'b10, 16'h00FF);
        ev_calib = 1; ev_limit = 1; step();
        check(irq == 1'b0, "R10 lane kept", {15'b0, irq}, 16'h0000);
        clear_flags();
        write_ien(2'b11, 16'h00FF);
        ev_limit = 1; ev_autozero = 1; ev_calib = 1; ev_pause = 1; ev_ready = 1;
        ld_valid = 1; ld_num = 3'd0; step();
        check(rd_data == 16'h00BB, "R2 spare zero", rd_data, 16'h00BB);
        check(irq == 1'b1, "R9 any", {15'b0, irq}, 16'h0001);
        clear_flags();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_events();
        t_load_match();
        t_count();
        t_threshold();
        t_collide();
        t_irq_lanes();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule